// File: doc/BRIEF.md
# Transmit FIFO with Free-Space Interrupt

This block buffers outgoing bytes between a host and a serial transmitter. The host pushes bytes with a write strobe. The transmitter takes the oldest byte with a pop strobe. Storage holds 64 bytes and is split into two equal banks; the pointer's top bit selects the bank.

A six-bit threshold sets how many free byte slots must exist before the block asks the host for more data. The request, called the transmit-empty interrupt, is pending out of reset. It therefore appears the moment the host sets the enable mask. There are two interrupt modes:

- **Latched mode:** a request stays up until the host strobes an interrupt-register read.
- **Dynamic mode:** the output is a level that follows the free-slot count against the threshold.

Top module: `txf_ctrl`

## Requirements
- R1: After reset the FIFO is empty (`empty`=1, `full`=0, `free_cnt`=64) and `ovf_flag`=0. The interrupt condition is pending, so `tx_irq` equals `irq_mask`.
- R2: Bytes leave in the order they were written. While the FIFO is not empty, `rd_data` shows the oldest byte, and a pop moves on to the next one.
- R3: `free_cnt` equals 64 minus the number of stored bytes and updates at the clock edge that accepts a write or a pop. An accepted write together with an accepted pop leaves it unchanged.
- R4: `full` is 1 when 64 bytes are stored. A write while full changes neither the contents nor the count. It sets `ovf_flag`, which then stays 1 until reset.
- R5: A pop while empty leaves the count at 0 and drives `underrun` to 1 in that same cycle. `rd_data` reads 0 whenever the FIFO is empty.
- R6: With `dyn_mode`=1, `tx_irq` = `irq_mask` AND (`free_cnt` >= `irq_thresh`), following the registered count with no further delay.
- R7: With `dyn_mode`=0, a pending request is set one cycle after `free_cnt` changes from below the threshold to at or above it. It then stays set without an acknowledge, and `tx_irq` = pending AND `irq_mask`.
- R8: A one-cycle `irq_ack` clears the pending request at the next edge. If a new crossing happens in the same cycle, the set takes priority.
- R9: With `irq_mask`=0, `tx_irq` is 0 in both modes. The pending request is kept and shows once the mask is raised.
- R10: With threshold 32 and 33 bytes stored, the latched interrupt is absent. It appears one cycle after the first pop leaves 32 slots free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to store |
| pop_en | input | 1 | Transmitter pop strobe |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| empty | output | 1 | No bytes stored |
| full | output | 1 | 64 bytes stored |
| free_cnt | output | 7 | Number of free byte slots |
| ovf_flag | output | 1 | Sticky flag for a write to a full FIFO |
| underrun | output | 1 | Pop attempted on an empty FIFO |
| irq_thresh | input | 6 | Free-slot threshold for the interrupt |
| irq_mask | input | 1 | Interrupt enable |
| dyn_mode | input | 1 | 1 selects level mode, 0 selects latched mode |
| irq_ack | input | 1 | Interrupt-register read strobe |
| tx_irq | output | 1 | Transmit-empty interrupt |

## Verification
**Dynamic mode.** Every threshold from 0 to 63 is tried at every fill level from 0 to 64. This shows whether the comparison uses `>=` rather than `>`, and whether it counts free slots rather than stored bytes.

**Latched mode.** The FIFO is filled and then drained one byte at a time for several thresholds. This shows the single-cycle delay of the latch, its hold without an acknowledge, and the exact crossing point. The 32/33 case and an acknowledge that lands on a crossing are also tried.

**Data path.** Full, overflow, underrun and simultaneous push-and-pop patterns run with pointers that wrap across both banks, checking byte order and the sticky flag.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // free slots for a given occupancy
  function automatic int unsigned free_slots(int unsigned depth, int unsigned occ);
    return depth - occ;
  endfunction

  // threshold test on free slots
  function automatic logic slots_meet(int unsigned free_n, int unsigned thr);
    return free_n >= thr;
  endfunction

  // next occupancy after accepted strobes
  function automatic int unsigned next_occ(int unsigned occ, logic inc, logic dec);
    return occ + 32'(inc) - 32'(dec);
  endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int BANKS = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_acc,
  output logic [DW-1:0] head_data
);
  localparam int BANK_D = DEPTH / BANKS;
  localparam int OFS_W  = $clog2(BANK_D);
  localparam int SEL_W  = AW - OFS_W;

  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [DW-1:0]  bank_q [BANKS];
  logic [SEL_W-1:0] wr_sel, rd_sel;

  assign wr_sel = wr_ptr[AW-1 -: SEL_W];
  assign rd_sel = rd_ptr[AW-1 -: SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_acc)  wr_ptr <= wr_ptr + 1'b1;
      if (pop_acc) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [BANK_D];
    always_ff @(posedge clk) begin
      if (wr_acc && wr_sel == SEL_W'(b))
        mem[wr_ptr[OFS_W-1:0]] <= wr_data;
    end
    assign bank_q[b] = mem[rd_ptr[OFS_W-1:0]];
  end

  assign head_data = bank_q[rd_sel];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |=> rd_ptr == $past(rd_ptr) + 1'b1); // R2

endmodule

// File: rtl/txf_level.sv
module txf_level #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pop_en,
  output logic          wr_acc,
  output logic          pop_acc,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] free_n,
  output logic          ovf,
  output logic          underrun
);
  logic [CW-1:0] occ;
  logic          wr_blocked;

  assign full       = (occ == CW'(DEPTH));
  assign empty      = (occ == '0);
  assign wr_acc     = wr_en && !full;
  assign pop_acc    = pop_en && !empty;
  assign wr_blocked = wr_en && full;
  assign underrun   = pop_en && empty;
  assign free_n     = CW'(txf_pkg::free_slots(DEPTH, 32'(occ)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      ovf <= 1'b0;
    end else begin
      occ <= CW'(txf_pkg::next_occ(32'(occ), wr_acc, pop_acc));
      if (wr_blocked) ovf <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R3
  AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && pop_acc) |=> $stable(free_n)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop_en) |=> (full && $stable(free_n))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_en && !wr_en) |=> empty); // R5

endmodule

// File: rtl/txf_irq.sv
module txf_irq #(
  parameter int CW    = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    free_n,
  input  logic [THR_W-1:0] thresh,
  input  logic             mask,
  input  logic             dyn,
  input  logic             ack,
  output logic             irq
);
  logic meet, meet_q, rise, pending;

  assign meet = txf_pkg::slots_meet(32'(free_n), 32'(thresh));
  assign rise = meet && !meet_q;

  // pending starts set; a fresh crossing beats an acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meet_q  <= 1'b1;
      pending <= 1'b1;
    end else begin
      meet_q <= meet;
      if (rise)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  assign irq = mask && (dyn ? meet : pending);

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pending); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rise) |=> !pending); // R8
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq); // R9

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int BANKS = 2,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] free_cnt,
  output logic          ovf_flag,
  output logic          underrun,
  input  logic [AW-1:0] irq_thresh,
  input  logic          irq_mask,
  input  logic          dyn_mode,
  input  logic          irq_ack,
  output logic          tx_irq
);
  logic          wr_acc, pop_acc;
  logic [DW-1:0] head_data;

  txf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pop_en(pop_en),
    .wr_acc(wr_acc), .pop_acc(pop_acc), .full(full), .empty(empty),
    .free_n(free_cnt), .ovf(ovf_flag), .underrun(underrun)
  );

  txf_store #(.DW(DW), .DEPTH(DEPTH), .BANKS(BANKS), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
    .pop_acc(pop_acc), .head_data(head_data)
  );

  txf_irq #(.CW(CW), .THR_W(AW)) u_irq (
    .clk(clk), .rst_n(rst_n), .free_n(free_cnt), .thresh(irq_thresh),
    .mask(irq_mask), .dyn(dyn_mode), .ack(irq_ack), .irq(tx_irq)
  );

  assign rd_data = empty ? '0 : head_data;

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3

endmodule

// File: tb/test_txf_ctrl.sv
`timescale 1ns/1ps
module test_txf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, pop_en, irq_mask, dyn_mode, irq_ack;
  logic [7:0] wr_data, rd_data;
  logic [5:0] irq_thresh;
  logic       empty, full, ovf_flag, underrun, tx_irq;
  logic [6:0] free_cnt;

  int n_run = 0, n_fail = 0;
  logic seen_underrun;
  logic [7:0] model[$];

  always #10 clk = ~clk;

  txf_ctrl i_txf_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop_en(pop_en),
    .rd_data(rd_data), .empty(empty), .full(full), .free_cnt(free_cnt),
    .ovf_flag(ovf_flag), .underrun(underrun), .irq_thresh(irq_thresh),
    .irq_mask(irq_mask), .dyn_mode(dyn_mode), .irq_ack(irq_ack), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic p, input logic a);
    wr_en = w; wr_data = d; pop_en = p; irq_ack = a;
    #2 seen_underrun = underrun;
    @(negedge clk);
    wr_en = 1'b0; pop_en = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    if (model.size() < 64) model.push_back(d);
    cyc(1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic pop_chk();
    chk("R2", "rd_data", int'(rd_data), int'(model[0]));
    void'(model.pop_front());
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R3", "free_cnt", int'(free_cnt), 64 - model.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; pop_en = 0; irq_ack = 0; wr_data = 0;
    irq_mask = 1'b1; dyn_mode = 1'b0; irq_thresh = 6'd32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "free_cnt", int'(free_cnt), 64);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "tx_irq", int'(tx_irq), 1);
    irq_mask = 1'b0; #1;
    chk("R9", "masked irq", int'(tx_irq), 0);
    irq_mask = 1'b1; #1;
    chk("R9", "pending kept", int'(tx_irq), 1);

    // R8 acknowledge clears
    cyc(0, 0, 0, 1);
    chk("R8", "after ack", int'(tx_irq), 0);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R7", "no new crossing", int'(tx_irq), 0);

    // R10 threshold 32 with 33 bytes
    for (int i = 0; i < 33; i++) push(8'(i * 7 + 3));
    chk("R3", "free 31", int'(free_cnt), 31);
    dyn_mode = 1'b1; #1;
    chk("R6", "dyn below thr", int'(tx_irq), 0);
    dyn_mode = 1'b0; #1;
    chk("R10", "latched before pop", int'(tx_irq), 0);
    pop_chk();
    chk("R7", "one cycle delay", int'(tx_irq), 0);
    cyc(0, 0, 0, 0);
    chk("R10", "irq after first pop", int'(tx_irq), 1);
    dyn_mode = 1'b1; #1;
    chk("R6", "dyn at thr", int'(tx_irq), 1);
    dyn_mode = 1'b0;
    cyc(0, 0, 0, 1);
    chk("R8", "ack clears", int'(tx_irq), 0);

    // R8 set wins over ack on a crossing
    push(8'h5A);
    cyc(0, 0, 0, 0);
    chk("R8", "below thr", int'(tx_irq), 0);
    chk("R2", "rd_data", int'(rd_data), int'(model[0]));
    void'(model.pop_front());
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 1);
    chk("R8", "set beats ack", int'(tx_irq), 1);
    cyc(0, 0, 0, 1);
    chk("R8", "later ack", int'(tx_irq), 0);

    // R3 simultaneous push and pop
    chk("R2", "rd_data sim", int'(rd_data), int'(model[0]));
    void'(model.pop_front());
    model.push_back(8'hA5);
    cyc(1, 8'hA5, 1, 0);
    chk("R3", "sim free", int'(free_cnt), 32);

    // drain, then underrun
    while (model.size() > 0) pop_chk();
    cyc(0, 0, 1, 0);
    chk("R5", "underrun", int'(seen_underrun), 1);
    chk("R5", "free stays", int'(free_cnt), 64);
    chk("R5", "rd_data empty", int'(rd_data), 0);
    chk("R5", "empty", int'(empty), 1);

    // R4 full and overflow, pointers wrap across banks
    for (int i = 0; i < 64; i++) push(8'(i * 13 + 1));
    chk("R4", "full", int'(full), 1);
    chk("R4", "free 0", int'(free_cnt), 0);
    chk("R4", "no ovf yet", int'(ovf_flag), 0);
    push(8'hEE);
    chk("R4", "ovf set", int'(ovf_flag), 1);
    chk("R4", "free unchanged", int'(free_cnt), 0);
    while (model.size() > 0) pop_chk();
    chk("R4", "ovf sticky", int'(ovf_flag), 1);
    chk("R4", "empty after drain", int'(empty), 1);

    // R6 dynamic sweep over all thresholds and fill levels
    dyn_mode = 1'b1;
    for (int t = 0; t < 64; t++) begin
      irq_thresh = 6'(t);
      for (int occ = 0; occ <= 64; occ++) begin
        #1 chk("R6", "dyn level", int'(tx_irq), ((64 - occ) >= t) ? 1 : 0);
        if (occ < 64) push(8'(t + occ));
      end
      while (model.size() > 0) pop_chk();
    end
    irq_thresh = 6'd0; irq_mask = 1'b0; #1;
    chk("R9", "dyn masked", int'(tx_irq), 0);
    irq_mask = 1'b1;

    // R7 latched drain for several thresholds
    dyn_mode = 1'b0;
    for (int k = 0; k < 5; k++) begin
      int t;
      t = (k == 0) ? 1 : (k == 1) ? 16 : (k == 2) ? 32 : (k == 3) ? 48 : 63;
      irq_thresh = 6'(t);
      for (int i = 0; i < 64; i++) push(8'(i ^ t));
      cyc(0, 0, 0, 1);
      chk("R7", "cleared when full", int'(tx_irq), 0);
      if (t == 48) irq_mask = 1'b0;
      while (model.size() > 0) begin
        int f;
        pop_chk();
        f = 64 - model.size();
        if (f == t) chk("R7", "not before delay", int'(tx_irq), 0);
        cyc(0, 0, 0, 0);
        chk("R7", "latched", int'(tx_irq), (t != 48 && f >= t) ? 1 : 0);
      end
      if (t == 48) begin
        irq_mask = 1'b1; #1;
        chk("R9", "kept under mask", int'(tx_irq), 1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule